// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register file of one descriptor-driven DMA channel. Software changes the channel's run state through a control word whose upper half is a per-bit write enable and whose lower half carries the new values. The block folds every such write into a 32-bit status image. Three kinds of bit live in that image. Software alone owns run and pause. Software sets wake and flush, and hardware clears them. Hardware alone owns active, dead and branch-taken.

The block also holds the aligned command pointer and three condition-select words that the sequencer uses for its interrupt, branch and wait tests. It drives the channel-active level, a one-cycle flush request to the data mover and a strobe that tells the sequencer to fetch a descriptor. The sequencer and the data mover report their effects through per-bit set and clear requests.

A control write takes effect in two steps. In the cycle after the write, the flush request is up, and if flush was written it can be seen in the status. One cycle later the final status is committed and flush drops. Register reads return data one cycle after the request.

Top module: `chanCsr`

## Requirements
- R1: After reset, every readable register returns zero, and the active, flush-request, load-strobe and error outputs are low.
- R2: A write to the control offset 0x00 changes a run, pause, wake or flush bit only when that bit's enable (bit position + 16) is 1. A value bit whose enable is 0 has no effect.
- R3: With its enable set, run value 1 sets RUN (status bit 15). Run value 0 clears both RUN and DEAD (bit 11). Hardware requests cannot change RUN.
- R4: Wake value 1 with its enable set sets WAKE (bit 12) only if RUN is 1 after the same write. If RUN is 0, the write leaves WAKE and ACTIVE unchanged.
- R5: With its enable set, PAUSE (bit 14) takes the written value. After any control write, ACTIVE (bit 10) is 0 if PAUSE is 1 or RUN is 0, and a flush request is raised. Otherwise ACTIVE becomes 1 if the run or pause enable was set, or if wake was written as 1. Otherwise ACTIVE is unchanged.
- R6: A flush value 1 with its enable set makes FLUSH (bit 13) read 1 only in the cycle after the write. flushReq is high in that same cycle. One cycle later the final status is committed with FLUSH 0.
- R7: Reading the control offset returns the status word, the same as reading the status offset 0x04.
- R8: A write to the command pointer (0x0C) is ignored while ACTIVE is 1. An accepted write stores the value with bits 3:0 cleared, and cmdPtrLoad pulses for one cycle.
- R9: Offsets other than 0x00, 0x04, 0x0C, 0x10, 0x14 and 0x18 read as zero and ignore writes. An access whose byte enables are not all set, or whose address is not word aligned, changes nothing and pulses regErr.
- R10: hwSet and hwClr bit i act on one status bit: 0 ACTIVE, 1 FLUSH, 2 WAKE, 3 BT (bit 8), 4 DEAD. When both are set for the same bit, clear wins.
- R11: The interrupt (0x10), branch (0x14) and wait (0x18) select registers keep only bits 19:16 and 3:0 of a write. Other bits read as zero.
- R12: A write to the status offset changes only the device-status field, bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write request |
| regRd | input | 1 | Register read request |
| regAddr | input | ADDR_W | Byte offset of the access |
| regByteEn | input | 4 | Byte enables; all four are required |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRd |
| regErr | output | 1 | Pulse for an illegal access |
| hwSet | input | 5 | Hardware set requests, one per bit of R10 |
| hwClr | input | 5 | Hardware clear requests, same order |
| chanActive | output | 1 | Status ACTIVE bit |
| flushReq | output | 1 | One-cycle flush request to the data mover |
| cmdPtrLoad | output | 1 | Descriptor-fetch strobe |
| cmdPtr | output | 32 | Aligned command pointer |
| statusOut | output | 32 | Status image |
| intrSel | output | 32 | Interrupt condition select |
| branchSel | output | 32 | Branch condition select |
| waitSel | output | 32 | Wait condition select |

## Verification
A wrong status bit shows on statusOut and on a status read two cycles after the offending control write. A wrong flush decision shows on flushReq in the cycle right after the write. The bench sweeps every run, pause, wake and flush enable/value combination from idle, running and paused starting states, and checks the flush-phase image, the flush request and the committed image against an arithmetic model. A broken command-pointer lock shows on cmdPtrLoad in the cycle after the write, and on cmdPtr at the same time.

// File: rtl/chanCsrPkg.sv
package chanCsrPkg;
  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_FLUSH  = 13;
  localparam int BIT_WAKE   = 12;
  localparam int BIT_DEAD   = 11;
  localparam int BIT_ACTIVE = 10;
  localparam int BIT_BT     = 8;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_CMDPTR = 'h0C;
  localparam int OFS_INTR   = 'h10;
  localparam int OFS_BRANCH = 'h14;
  localparam int OFS_WAIT   = 'h18;

  localparam int HW_ACTIVE = 0;
  localparam int HW_FLUSH  = 1;
  localparam int HW_WAKE   = 2;
  localparam int HW_BT     = 3;
  localparam int HW_DEAD   = 4;
  localparam int HW_N      = 5;

  localparam int SEL_N = 3;

  typedef enum logic [2:0] {
    RS_STATUS, RS_CMDPTR, RS_INTR, RS_BRANCH, RS_WAIT, RS_ZERO
  } rdSel_e;

  typedef struct packed {
    logic commit;
    logic run;
    logic pause;
    logic wake;
    logic active;
    logic clrDead;
    logic flushDone;
  } swCommit_t;

  typedef struct packed {
    swCommit_t        cmt;
    logic             setFlush;
    logic             wrDev;
    logic             wrCmdPtr;
    logic [SEL_N-1:0] wrSel;
    logic             rdEn;
    rdSel_e           rdSel;
  } ctrlStrb_t;

  function automatic int hwBitPos(input int idx);
    case (idx)
      HW_ACTIVE: return BIT_ACTIVE;
      HW_FLUSH:  return BIT_FLUSH;
      HW_WAKE:   return BIT_WAKE;
      HW_BT:     return BIT_BT;
      default:   return BIT_DEAD;
    endcase
  endfunction

  function automatic logic [31:0] applyCommit(input logic [31:0] s, input swCommit_t c);
    logic [31:0] r;
    r = s;
    r[BIT_RUN]    = c.run;
    r[BIT_PAUSE]  = c.pause;
    r[BIT_WAKE]   = c.wake;
    r[BIT_ACTIVE] = c.active;
    if (c.clrDead)   r[BIT_DEAD]  = 1'b0;
    if (c.flushDone) r[BIT_FLUSH] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/chanCsrCtrl.sv
module chanCsrCtrl
  import chanCsrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       statusQ,
  output ctrlStrb_t         strb,
  output logic              flushReq,
  output logic              regErr
);
  logic        pendValidQ;
  swCommit_t   pendQ;
  logic        pendReqQ;
  logic        errQ;
  logic [31:0] view;
  logic        legal, wrOk, rdOk, ctrlWr;
  logic        hitCtrl, hitStatus, hitCmd, hitIntr, hitBr, hitWait;
  logic [15:0] wMask, wVal;
  logic        nRun, nPause, nWake, nActive, flushBit, stopping, wakeWr;
  swCommit_t   nextPend;

  always_comb begin
    view = pendValidQ ? applyCommit(statusQ, pendQ) : statusQ;
  end

  assign legal     = (regByteEn == 4'hF) && (regAddr[1:0] == 2'b00);
  assign wrOk      = regWr && legal;
  assign rdOk      = regRd && legal;
  assign hitCtrl   = regAddr == ADDR_W'(OFS_CTRL);
  assign hitStatus = regAddr == ADDR_W'(OFS_STATUS);
  assign hitCmd    = regAddr == ADDR_W'(OFS_CMDPTR);
  assign hitIntr   = regAddr == ADDR_W'(OFS_INTR);
  assign hitBr     = regAddr == ADDR_W'(OFS_BRANCH);
  assign hitWait   = regAddr == ADDR_W'(OFS_WAIT);
  assign ctrlWr    = wrOk && hitCtrl;

  assign wMask = regWrData[31:16];
  assign wVal  = regWrData[15:0];

  // Evaluate a masked control write against the up-to-date status view
  always_comb begin
    nRun     = wMask[BIT_RUN] ? wVal[BIT_RUN] : view[BIT_RUN];
    wakeWr   = wMask[BIT_WAKE] && wVal[BIT_WAKE];
    nWake    = view[BIT_WAKE] || (wakeWr && nRun);
    nPause   = wMask[BIT_PAUSE] ? wVal[BIT_PAUSE] : view[BIT_PAUSE];
    flushBit = wMask[BIT_FLUSH] && wVal[BIT_FLUSH];
    stopping = nPause || !nRun;
    if (stopping)
      nActive = 1'b0;
    else if (wMask[BIT_RUN] || wMask[BIT_PAUSE] || wakeWr)
      nActive = 1'b1;
    else
      nActive = view[BIT_ACTIVE];
    nextPend.commit    = 1'b1;
    nextPend.run       = nRun;
    nextPend.pause     = nPause;
    nextPend.wake      = nWake;
    nextPend.active    = nActive;
    nextPend.clrDead   = wMask[BIT_RUN] && !wVal[BIT_RUN];
    nextPend.flushDone = flushBit;
  end

  always_comb begin
    strb            = '0;
    strb.cmt        = pendQ;
    strb.cmt.commit = pendValidQ;
    strb.setFlush   = ctrlWr && flushBit;
    strb.wrDev      = wrOk && hitStatus;
    strb.wrCmdPtr   = wrOk && hitCmd && !view[BIT_ACTIVE];
    strb.wrSel      = {SEL_N{wrOk}} & {hitWait, hitBr, hitIntr};
    strb.rdEn       = rdOk;
    if (hitCtrl || hitStatus) strb.rdSel = RS_STATUS;
    else if (hitCmd)          strb.rdSel = RS_CMDPTR;
    else if (hitIntr)         strb.rdSel = RS_INTR;
    else if (hitBr)           strb.rdSel = RS_BRANCH;
    else if (hitWait)         strb.rdSel = RS_WAIT;
    else                      strb.rdSel = RS_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValidQ <= 1'b0;
      pendQ      <= '0;
      pendReqQ   <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      pendValidQ <= ctrlWr;
      if (ctrlWr) pendQ <= nextPend;
      pendReqQ   <= ctrlWr && (flushBit || stopping);
      errQ       <= (regWr || regRd) && !legal;
    end
  end

  assign flushReq = pendValidQ && pendReqQ;
  assign regErr   = errQ;

  AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(regWr && legal && hitCtrl)); // R6
  AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> !pendValidQ); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlWr, strb.wrDev, strb.wrCmdPtr, strb.wrSel})); // R9
endmodule

// File: rtl/chanCsrData.sv
module chanCsrData
  import chanCsrPkg::*;
#(
  parameter int SEL_W          = 4,
  parameter int CMD_ALIGN_BITS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [31:0]     regWrData,
  input  logic [HW_N-1:0] hwSet,
  input  logic [HW_N-1:0] hwClr,
  output logic [31:0]     statusQ,
  output logic [31:0]     cmdPtrQ,
  output logic            cmdPtrLoad,
  output logic [31:0]     regRdData,
  output logic [31:0]     intrSel,
  output logic [31:0]     branchSel,
  output logic [31:0]     waitSel
);
  localparam logic [31:0] FIELD_ONES = (32'd1 << SEL_W) - 32'd1;
  localparam logic [31:0] SEL_KEEP   = FIELD_ONES | (FIELD_ONES << 16);
  localparam logic [31:0] PTR_KEEP   = ~((32'd1 << CMD_ALIGN_BITS) - 32'd1);

  logic [31:0] statusNext;
  logic [31:0] selQ [SEL_N];
  logic        loadQ;
  logic [31:0] rdQ;
  logic [31:0] rdMux;

  always_comb begin
    statusNext = statusQ;
    if (strb.cmt.commit) statusNext = applyCommit(statusNext, strb.cmt);
    if (strb.setFlush)   statusNext[BIT_FLUSH] = 1'b1;
    if (strb.wrDev)      statusNext[3:0] = regWrData[3:0];
    for (int i = 0; i < HW_N; i++) begin
      if (hwSet[i]) statusNext[hwBitPos(i)] = 1'b1;
      if (hwClr[i]) statusNext[hwBitPos(i)] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      cmdPtrQ <= '0;
      loadQ   <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strb.wrCmdPtr) cmdPtrQ <= regWrData & PTR_KEEP;
      loadQ   <= strb.wrCmdPtr;
    end
  end

  for (genvar g = 0; g < SEL_N; g++) begin : gSel
    always_ff @(posedge clk) begin
      if (!rstN)             selQ[g] <= '0;
      else if (strb.wrSel[g]) selQ[g] <= regWrData & SEL_KEEP;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RS_STATUS: rdMux = statusQ;
      RS_CMDPTR: rdMux = cmdPtrQ;
      RS_INTR:   rdMux = selQ[0];
      RS_BRANCH: rdMux = selQ[1];
      RS_WAIT:   rdMux = selQ[2];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (strb.rdEn) rdQ <= rdMux;
  end

  assign regRdData  = rdQ;
  assign cmdPtrLoad = loadQ;
  assign intrSel    = selQ[0];
  assign branchSel  = selQ[1];
  assign waitSel    = selQ[2];

  AST_RUN_ONLY_BY_SW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[BIT_RUN]) |-> $past(strb.cmt.commit)); // R3
  AST_DEAD_CLEARED_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.cmt.commit && strb.cmt.clrDead && !hwSet[HW_DEAD]) |-> !statusQ[BIT_DEAD]); // R3
  AST_PAUSE_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.cmt.commit && (strb.cmt.pause || !strb.cmt.run) && !hwSet[HW_ACTIVE])
      |-> !statusQ[BIT_ACTIVE]); // R5
  AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrCmdPtr) |-> $stable(cmdPtrQ)); // R8
endmodule

// File: rtl/chanCsr.sv
module chanCsr
  import chanCsrPkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int SEL_W          = 4,
  parameter int CMD_ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              regErr,
  input  logic [4:0]        hwSet,
  input  logic [4:0]        hwClr,
  output logic              chanActive,
  output logic              flushReq,
  output logic              cmdPtrLoad,
  output logic [31:0]       cmdPtr,
  output logic [31:0]       statusOut,
  output logic [31:0]       intrSel,
  output logic [31:0]       branchSel,
  output logic [31:0]       waitSel
);
  ctrlStrb_t   strb;
  logic [31:0] statusQ;

  chanCsrCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .statusQ(statusQ),
    .strb(strb), .flushReq(flushReq), .regErr(regErr)
  );

  chanCsrData #(.SEL_W(SEL_W), .CMD_ALIGN_BITS(CMD_ALIGN_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .hwSet(hwSet), .hwClr(hwClr), .statusQ(statusQ), .cmdPtrQ(cmdPtr),
    .cmdPtrLoad(cmdPtrLoad), .regRdData(regRdData), .intrSel(intrSel),
    .branchSel(branchSel), .waitSel(waitSel)
  );

  assign statusOut  = statusQ;
  assign chanActive = statusQ[BIT_ACTIVE];
endmodule

// File: tb/chanCsr_tb.sv
`timescale 1ns/1ps
module chanCsr_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [3:0]  regByteEn = 4'hF;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regErr;
  logic [4:0]  hwSet = '0, hwClr = '0;
  logic        chanActive, flushReq, cmdPtrLoad;
  logic [31:0] cmdPtr, statusOut, intrSel, branchSel, waitSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chanCsr u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .regErr(regErr), .hwSet(hwSet), .hwClr(hwClr), .chanActive(chanActive),
    .flushReq(flushReq), .cmdPtrLoad(cmdPtrLoad), .cmdPtr(cmdPtr),
    .statusOut(statusOut), .intrSel(intrSel), .branchSel(branchSel), .waitSel(waitSel)
  );

  localparam logic [31:0] S_RUN = 32'h8000, S_PAUSE = 32'h4000, S_FLUSH = 32'h2000,
                          S_WAKE = 32'h1000, S_DEAD = 32'h0800, S_ACT = 32'h0400,
                          S_BT = 32'h0100;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    regAddr = a; regWrData = d; regByteEn = be; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regByteEn = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic hwPulse(input logic [4:0] s, input logic [4:0] c);
    hwSet = s; hwClr = c;
    @(negedge clk);
    hwSet = '0; hwClr = '0;
  endtask

  // Arithmetic model of a masked control write (R2..R5)
  function automatic void model(input logic [31:0] s, input logic [15:0] m, input logic [15:0] v,
                                output logic [31:0] n, output logic fl);
    logic stop;
    n = s;
    if (m[15] && v[15]) n = n | S_RUN;
    if (m[15] && !v[15]) n = n & ~(S_RUN | S_DEAD);
    if (m[12] && v[12] && n[15]) n = n | S_WAKE;
    if (m[14]) n = (n & ~S_PAUSE) | ({16'h0, v} & S_PAUSE);
    stop = n[14] || !n[15];
    if (stop) n = n & ~S_ACT;
    else if (m[15] || m[14] || (m[12] && v[12])) n = n | S_ACT;
    fl = stop || (m[13] && v[13]);
  endfunction

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s, n, ptrSave;
    logic fl;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset state
    foreach (d[i]) ; // no-op
    for (int a = 0; a < 32'h20; a += 4) begin
      rd(8'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 active", {31'h0, chanActive}, 0);
    check("R1 flushReq", {31'h0, flushReq}, 0);
    check("R1 load", {31'h0, cmdPtrLoad}, 0);
    check("R1 err", {31'h0, regErr}, 0);

    // R2: value without enable does nothing
    wr(8'h00, 32'h0000_F000); cyc();
    rd(8'h04, d);
    check("R2 unmasked value", d, 32'h0);

    // R3: run set, dead cleared by run=0
    wr(8'h00, 32'h8000_8000); cyc();
    rd(8'h04, d);
    check("R3 run set", d, S_RUN | S_ACT);
    check("R3 active out", {31'h0, chanActive}, 1);
    hwPulse(5'b10000, 5'b0);
    check("R3 dead via hw", statusOut, S_RUN | S_ACT | S_DEAD);
    wr(8'h00, 32'h8000_0000);
    check("R3 stop flush req", {31'h0, flushReq}, 1);
    cyc();
    check("R3 run and dead cleared", statusOut, 32'h0);

    // R4: wake ignored without run
    wr(8'h00, 32'h1000_1000); cyc();
    check("R4 wake without run", statusOut, 32'h0);
    wr(8'h00, 32'h8000_8000); cyc();
    hwPulse(5'b0, 5'b00001);
    check("R4 active dropped by hw", statusOut, S_RUN);
    wr(8'h00, 32'h1000_1000); cyc();
    check("R4 wake with run", statusOut, S_RUN | S_WAKE | S_ACT);
    hwPulse(5'b0, 5'b00100);

    // R5: pause
    wr(8'h00, 32'h4000_4000);
    check("R5 pause flush req", {31'h0, flushReq}, 1);
    cyc();
    check("R5 paused", statusOut, S_RUN | S_PAUSE);
    wr(8'h00, 32'h4000_0000);
    check("R5 resume no flush", {31'h0, flushReq}, 0);
    cyc();
    check("R5 resumed", statusOut, S_RUN | S_ACT);

    // R6: flush is transient
    wr(8'h00, 32'h2000_2000);
    check("R6 flushReq", {31'h0, flushReq}, 1);
    rd(8'h04, d);
    check("R6 flush visible", d, S_RUN | S_ACT | S_FLUSH);
    check("R6 flushReq one cycle", {31'h0, flushReq}, 0);
    rd(8'h04, d);
    check("R6 flush gone", d, S_RUN | S_ACT);

    // R7: control offset returns status
    rd(8'h00, d);
    check("R7 ctrl read", d, S_RUN | S_ACT);

    // R8: command pointer lock
    wr(8'h0C, 32'h1234_5678);
    check("R8 no load while active", {31'h0, cmdPtrLoad}, 0);
    check("R8 ptr held", cmdPtr, 32'h0);
    wr(8'h00, 32'h8000_0000); cyc();
    wr(8'h0C, 32'h1234_567F);
    check("R8 load strobe", {31'h0, cmdPtrLoad}, 1);
    check("R8 aligned", cmdPtr, 32'h1234_5670);
    cyc();
    check("R8 strobe one cycle", {31'h0, cmdPtrLoad}, 0);
    rd(8'h0C, d);
    check("R8 readback", d, 32'h1234_5670);

    // R9: unused offsets and illegal accesses
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d); check("R9 unused 0x1C", d, 0);
    rd(8'h08, d); check("R9 unused 0x08", d, 0);
    rd(8'h40, d); check("R9 unused 0x40", d, 0);
    ptrSave = cmdPtr;
    wr(8'h0C, 32'hAAAA_AAA0, 4'h3);
    check("R9 err partial", {31'h0, regErr}, 1);
    check("R9 ptr kept", cmdPtr, ptrSave);
    wr(8'h0E, 32'h5555_5550);
    check("R9 err misaligned", {31'h0, regErr}, 1);
    cyc();
    check("R9 err pulse", {31'h0, regErr}, 0);
    check("R9 ptr kept 2", cmdPtr, ptrSave);
    wr(8'h00, 32'h8000_8000, 4'h1); cyc();
    check("R9 partial ctrl ignored", statusOut, 32'h0);

    // R10: hardware set/clear, clear wins
    hwPulse(5'b01000, 5'b0);
    check("R10 bt set", statusOut, S_BT);
    hwPulse(5'b00110, 5'b00010);
    check("R10 clear wins", statusOut, S_BT | S_WAKE);
    hwPulse(5'b0, 5'b01100);
    check("R10 clears", statusOut, 32'h0);

    // R11: select registers
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1235_ABC9);
    wr(8'h18, 32'h000A_0005);
    rd(8'h10, d); check("R11 intr", d, 32'h000F_000F);
    rd(8'h14, d); check("R11 branch", d, 32'h0005_0009);
    rd(8'h18, d); check("R11 wait", d, 32'h000A_0005);
    check("R11 intr out", intrSel, 32'h000F_000F);
    check("R11 branch out", branchSel, 32'h0005_0009);
    check("R11 wait out", waitSel, 32'h000A_0005);

    // R12: status write touches device field only
    hwPulse(5'b01000, 5'b0);
    wr(8'h04, 32'hFFFF_FFF6);
    rd(8'h04, d);
    check("R12 device bits", d, S_BT | 32'h6);
    hwPulse(5'b0, 5'b01000);
    wr(8'h04, 32'h0);

    // Sweep: every enable/value combination of run, pause, wake, flush
    for (int init = 0; init < 3; init++) begin
      for (int c = 0; c < 256; c++) begin
        logic [15:0] m, v;
        wr(8'h00, 32'hC000_0000); cyc();
        hwPulse(5'b0, 5'b11111);
        s = 32'h0;
        if (init >= 1) begin wr(8'h00, 32'h8000_8000); cyc(); s = S_RUN | S_ACT; end
        if (init == 2) begin wr(8'h00, 32'h4000_4000); cyc(); s = S_RUN | S_PAUSE; end
        m = {c[0], c[1], c[2], c[3], 12'h0};
        v = {c[4], c[5], c[6], c[7], 12'h0};
        model(s, m, v, n, fl);
        wr(8'h00, {m, v});
        check("R5 sweep flushReq", {31'h0, flushReq}, {31'h0, fl});
        rd(8'h04, d);
        check("R6 sweep flush phase", d, s | ((m[13] && v[13]) ? S_FLUSH : 32'h0));
        rd(8'h00, d);
        check("R2 sweep committed", d, n);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule